// File: doc/BRIEF.md
# Image Encoder Host Register Slave

This block is the host-facing control and status window of an image compression core. A bus master reaches it over a 32-bit peripheral bus with select, read-not-write, byte enables, address, write data, read data and a transfer acknowledge. Through it the master can:
- load a 64-entry quantization table;
- program the frame width and height;
- set the number of colour components;
- launch a frame;
- poll a status word until the core reports that the frame is finished.

Toward the core the block drives a one-cycle start pulse, the component count, the width and height, and a combinational read port into the table, indexed by a 6-bit entry number. The core returns a one-cycle done pulse. The block answers each bus transfer with a single registered acknowledge. The retry, error-acknowledge and timeout-suppress outputs are tied inactive.

Top module: `enc_host_regs`

## Requirements
- R1: The acknowledge rises exactly one cycle after the first clock edge that samples select high, and stays high for one cycle. No further acknowledge is given while select stays high; a new transfer needs select to drop and rise again.
- R2: During a read acknowledge, read data carries the addressed register. At all other times read data is zero.
- R3: A write to offset 0x00 with byte lane 0 enabled and bit 0 set gives one high cycle on `frame_start`, in the cycle after the acknowledge. Bits 3:1 of that write load the component count. A read of 0x00 returns the count in bits 3:1 and 0 in bit 0.
- R4: Offset 0x04 holds the width in bits 31:16 and the height in bits 15:0. Each byte lane is written only when its byte enable is set. Both fields appear on `img_width` and `img_height` and read back unchanged.
- R5: Status bit 2 (size error) is set by a size write that leaves the low 3 bits of the width or of the height nonzero. It is cleared by a size write that leaves both fields multiples of 8.
- R6: A start request sets status bit 0 (busy) and clears status bit 1 (done).
- R7: A `core_done` pulse clears busy and sets done. With no size error, status at 0x0C then reads exactly 2. Done stays set until the next start. If a start and a done fall in the same cycle, the start wins.
- R8: Table entry i (0 to 63) lives at 0x100 + 4*i. It takes bits 7:0 of the write data, only when byte enable bit 0 is set, and reads back zero-extended.
- R9: `qt_val` shows the table entry selected by `qt_idx` in the same cycle, without any bus transfer.
- R10: Reads of any other address, including a table-window address whose low 2 bits are nonzero, return zero. Writes to such addresses, and to the status word, are acknowledged and change nothing.
- R11: `bus_retry`, `bus_err` and `bus_tout_sup` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Transfer select from the master |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_be | input | 4 | Byte enables, bit b covers data bits 8b+7:8b |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with the acknowledge |
| bus_ack | output | 1 | Transfer acknowledge |
| bus_retry | output | 1 | Retry request, held 0 |
| bus_err | output | 1 | Error acknowledge, held 0 |
| bus_tout_sup | output | 1 | Timeout suppression, held 0 |
| core_done | input | 1 | One-cycle frame-finished pulse from the core |
| frame_start | output | 1 | One-cycle frame launch pulse |
| comp_count | output | 3 | Colour component count |
| img_width | output | 16 | Frame width |
| img_height | output | 16 | Frame height |
| qt_idx | input | 6 | Table entry index for the core |
| qt_val | output | 8 | Table entry at `qt_idx` |

## Verification
The bench builds the block with the package defaults: a 64-entry table of 8-bit values, a 3-bit component count, 16-bit dimensions and a 3-bit alignment rule. With these values it can write and read every table entry on both read paths. It can hit every byte lane of the size word, and it can make either dimension misaligned on its own. Random table and size traffic runs against a bench model, and directed cases cover the rest: a select held high past its acknowledge, a start and a done in the same cycle, misaligned table addresses, and writes to the status word.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int ADDR_W        = 32;
    localparam int DATA_W        = 32;
    localparam int BE_W          = DATA_W / 8;
    localparam int DIM_W         = 16;
    localparam int COMP_W        = 3;
    localparam int QT_W          = 8;
    localparam int QT_DEPTH      = 64;
    localparam int QT_IDX_W      = $clog2(QT_DEPTH);
    localparam int STRIDE_LOG2   = 2;
    localparam int ALIGN_BITS    = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 32'h0000_0000;
    localparam logic [ADDR_W-1:0] OFS_SIZE    = 32'h0000_0004;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 32'h0000_000C;
    localparam logic [ADDR_W-1:0] OFS_QT_BASE = 32'h0000_0100;
    localparam logic [ADDR_W-1:0] QT_SPAN     = ADDR_W'(QT_DEPTH << STRIDE_LOG2);

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_SIZE,
        RG_STAT,
        RG_QT
    } region_e;

    typedef struct packed {
        region_e               region;
        logic [QT_IDX_W-1:0]   idx;
    } dec_t;

    // busy is the least significant bit, size error the most significant
    typedef struct packed {
        logic serr;
        logic done;
        logic busy;
    } status_t;

    // width occupies the upper half of the bus word
    typedef struct packed {
        logic [DIM_W-1:0] width;
        logic [DIM_W-1:0] height;
    } size_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.idx    = a[STRIDE_LOG2 +: QT_IDX_W];
        d.region = RG_NONE;
        if (a == OFS_CTRL)
            d.region = RG_CTRL;
        else if (a == OFS_SIZE)
            d.region = RG_SIZE;
        else if (a == OFS_STAT)
            d.region = RG_STAT;
        else if (a >= OFS_QT_BASE && a < OFS_QT_BASE + QT_SPAN &&
                 a[STRIDE_LOG2-1:0] == '0)
            d.region = RG_QT;
        return d;
    endfunction

    function automatic logic dim_aligned(input logic [DIM_W-1:0] v);
        return v[ALIGN_BITS-1:0] == '0;
    endfunction

endpackage

// File: rtl/hreg_bus_port.sv
module hreg_bus_port
    import hreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    output logic              ack,
    output logic              wr_fire,
    output dec_t              dec
);

    logic ack_q;
    logic served_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q    <= 1'b0;
            served_q <= 1'b0;
        end else begin
            ack_q <= sel & ~served_q & ~ack_q;
            if (!sel)
                served_q <= 1'b0;
            else if (ack_q)
                served_q <= 1'b1;
        end
    end

    assign ack     = ack_q;
    assign wr_fire = ack_q & sel & ~rnw;
    assign dec     = decode_addr(addr);

    // R1: acknowledge lasts a single cycle
    p_ack_one_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    // R1: acknowledge only follows a sampled select
    p_ack_after_sel_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(sel));

    // R1: a held select never earns a second acknowledge
    p_no_reack_r1: assert property (@(posedge clk) disable iff (rst)
        (ack_q && sel) |=> (sel |=> !ack_q));

endmodule

// File: rtl/hreg_ctrl_stat.sv
module hreg_ctrl_stat
    import hreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_size,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              core_done,
    output logic              frame_start,
    output logic [COMP_W-1:0] comp_count,
    output size_t             size_q,
    output status_t           status
);

    logic              start_req;
    logic              start_q;
    logic [COMP_W-1:0] comp_q;
    logic [DATA_W-1:0] lane_mask;
    size_t             size_nx;
    status_t           stat_q;

    assign start_req = wr_ctrl & be[0] & wdata[0];

    // per-lane write mask built from byte enables
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{be[b]}};
    end

    assign size_nx = size_t'((wdata & lane_mask) | (DATA_W'(size_q) & ~lane_mask));

    always_ff @(posedge clk) begin
        if (rst) begin
            comp_q  <= '0;
            start_q <= 1'b0;
            size_q  <= '0;
            stat_q  <= '0;
        end else begin
            start_q <= start_req;
            if (wr_ctrl && be[0])
                comp_q <= wdata[COMP_W:1];
            if (wr_size) begin
                size_q      <= size_nx;
                stat_q.serr <= ~(dim_aligned(size_nx.width) & dim_aligned(size_nx.height));
            end
            if (start_req) begin
                stat_q.busy <= 1'b1;
                stat_q.done <= 1'b0;
            end else if (core_done) begin
                stat_q.busy <= 1'b0;
                stat_q.done <= 1'b1;
            end
        end
    end

    assign frame_start = start_q;
    assign comp_count  = comp_q;
    assign status      = stat_q;

    // R3: start pulse is one cycle wide
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R6: a launched frame is busy and not done
    p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (status.busy && !status.done));

    // R7: done pulse without a competing start finishes the frame
    p_done_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (core_done && !start_req) |=> (status.done && !status.busy));

    // R7: done is sticky until a start
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (status.done && !start_req) |=> status.done);

endmodule

// File: rtl/hreg_qtable.sv
module hreg_qtable
    import hreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [QT_IDX_W-1:0] wr_idx,
    input  logic [QT_W-1:0]     wdata,
    input  logic [QT_IDX_W-1:0] bus_idx,
    output logic [QT_W-1:0]     bus_val,
    input  logic [QT_IDX_W-1:0] core_idx,
    output logic [QT_W-1:0]     core_val
);

    logic [QT_W-1:0] mem [QT_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < QT_DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wdata;
        end
    end

    assign bus_val  = mem[bus_idx];
    assign core_val = mem[core_idx];

    // R8: a committed write lands in the addressed entry
    p_qt_write_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_idx)] == $past(wdata)));

    // R9: entries only move on a write
    p_qt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(core_val) || $changed(core_idx));

endmodule

// File: rtl/enc_host_regs.sv
module enc_host_regs
    import hreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_rnw,
    input  logic [BE_W-1:0]     bus_be,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ack,
    output logic                bus_retry,
    output logic                bus_err,
    output logic                bus_tout_sup,
    input  logic                core_done,
    output logic                frame_start,
    output logic [COMP_W-1:0]   comp_count,
    output logic [DIM_W-1:0]    img_width,
    output logic [DIM_W-1:0]    img_height,
    input  logic [QT_IDX_W-1:0] qt_idx,
    output logic [QT_W-1:0]     qt_val
);

    logic              wr_fire;
    dec_t              dec;
    size_t             size_q;
    status_t           status;
    logic [QT_W-1:0]   qt_bus_val;
    logic [DATA_W-1:0] rd_mux;

    hreg_bus_port u_port (
        .clk     (clk),
        .rst     (rst),
        .sel     (bus_sel),
        .rnw     (bus_rnw),
        .addr    (bus_addr),
        .ack     (bus_ack),
        .wr_fire (wr_fire),
        .dec     (dec)
    );

    hreg_ctrl_stat u_cs (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (wr_fire && dec.region == RG_CTRL),
        .wr_size     (wr_fire && dec.region == RG_SIZE),
        .be          (bus_be),
        .wdata       (bus_wdata),
        .core_done   (core_done),
        .frame_start (frame_start),
        .comp_count  (comp_count),
        .size_q      (size_q),
        .status      (status)
    );

    hreg_qtable u_qt (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_fire && dec.region == RG_QT && bus_be[0]),
        .wr_idx   (dec.idx),
        .wdata    (bus_wdata[QT_W-1:0]),
        .bus_idx  (dec.idx),
        .bus_val  (qt_bus_val),
        .core_idx (qt_idx),
        .core_val (qt_val)
    );

    always_comb begin
        rd_mux = '0;
        case (dec.region)
            RG_CTRL: rd_mux = DATA_W'({comp_count, 1'b0});
            RG_SIZE: rd_mux = DATA_W'(size_q);
            RG_STAT: rd_mux = DATA_W'(status);
            RG_QT:   rd_mux = DATA_W'(qt_bus_val);
            default: rd_mux = '0;
        endcase
    end

    assign bus_rdata    = (bus_ack && bus_sel && bus_rnw) ? rd_mux : '0;
    assign bus_retry    = 1'b0;
    assign bus_err      = 1'b0;
    assign bus_tout_sup = 1'b0;
    assign img_width    = size_q.width;
    assign img_height   = size_q.height;

    // R2: read data is quiet outside an acknowledge
    p_rdata_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> bus_rdata == '0);

    // R4: size outputs only move on a write acknowledge
    p_size_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(bus_ack && !bus_rnw) |=> ($stable(img_width) && $stable(img_height)));

endmodule

// File: tb/enc_host_regs_tb_top.sv
module enc_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_rnw = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_retry, bus_err, bus_tout_sup;
    logic        core_done = 1'b0;
    logic        frame_start;
    logic [2:0]  comp_count;
    logic [15:0] img_width, img_height;
    logic [5:0]  qt_idx = '0;
    logic [7:0]  qt_val;

    int tests = 0, fails = 0;
    bit finished = 0;

    // bench model
    logic [7:0]  qt_m [64];
    logic [31:0] size_m;
    logic [2:0]  comp_m;
    logic        busy_m, done_m, serr_m;
    logic        start_seen, start_after;

    always #2 clk = ~clk;

    enc_host_regs dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rnw(bus_rnw), .bus_be(bus_be),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_retry(bus_retry), .bus_err(bus_err),
        .bus_tout_sup(bus_tout_sup), .core_done(core_done), .frame_start(frame_start),
        .comp_count(comp_count), .img_width(img_width), .img_height(img_height),
        .qt_idx(qt_idx), .qt_val(qt_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] status_word();
        return {29'b0, serr_m, done_m, busy_m};
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        if (a == 32'h0) return {28'b0, comp_m, 1'b0};
        if (a == 32'h4) return size_m;
        if (a == 32'hC) return status_word();
        if (a >= 32'h100 && a < 32'h200 && a[1:0] == 2'b00) return {24'b0, qt_m[a[7:2]]};
        return 32'h0;
    endfunction

    function automatic logic [31:0] merge_be(input logic [31:0] old, input logic [31:0] d,
                                             input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++)
            if (be[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    // model update for a write, applied when the write commits
    task automatic model_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                               input logic done_same);
        if (a == 32'h0 && be[0]) begin
            comp_m = d[3:1];
            if (d[0]) begin busy_m = 1; done_m = 0; end
            else if (done_same) begin busy_m = 0; done_m = 1; end
        end else begin
            if (done_same) begin busy_m = 0; done_m = 1; end
            if (a == 32'h4) begin
                size_m = merge_be(size_m, d, be);
                serr_m = (size_m[18:16] != 0) || (size_m[2:0] != 0);
            end else if (a >= 32'h100 && a < 32'h200 && a[1:0] == 2'b00 && be[0]) begin
                qt_m[a[7:2]] = d[7:0];
            end
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                             input logic done_same);
        @(negedge clk);
        bus_sel = 1; bus_rnw = 0; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        chk("R1 write ack one cycle after select", {31'b0, bus_ack}, 32'd1);
        core_done = done_same;
        @(negedge clk);
        core_done = 0;
        chk("R1 write ack drops", {31'b0, bus_ack}, 32'd0);
        start_seen = frame_start;
        bus_sel = 0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
        model_write(a, d, be, done_same);
        @(negedge clk);
        start_after = frame_start;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rnw = 1; bus_addr = a; bus_be = 4'hF;
        @(negedge clk);
        chk("R1 read ack one cycle after select", {31'b0, bus_ack}, 32'd1);
        d = bus_rdata;
        @(negedge clk);
        chk("R2 read data zero after ack", bus_rdata, 32'd0);
        bus_sel = 0; bus_rnw = 0; bus_addr = '0; bus_be = '0;
    endtask

    task automatic read_chk(input string req, input logic [31:0] a);
        logic [31:0] d;
        bus_read(a, d);
        chk(req, d, exp_read(a));
    endtask

    task automatic pulse_done();
        @(negedge clk);
        core_done = 1;
        @(negedge clk);
        core_done = 0;
        busy_m = 0; done_m = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int acks;
        int starts;
        for (int i = 0; i < 64; i++) qt_m[i] = '0;
        size_m = '0; comp_m = '0; busy_m = 0; done_m = 0; serr_m = 0;
        void'($urandom(32'h1234_5678));

        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // reset state
        chk("R1 reset ack low", {31'b0, bus_ack}, 32'd0);
        chk("R3 reset start low", {31'b0, frame_start}, 32'd0);
        chk("R4 reset size", {img_width, img_height}, 32'd0);
        chk("R11 side outputs low", {29'b0, bus_retry, bus_err, bus_tout_sup}, 32'd0);
        chk("R2 idle read data", bus_rdata, 32'd0);
        read_chk("R6 reset status", 32'hC);

        // size program: 320 x 240
        bus_write(32'h4, 32'h0140_00F0, 4'hF, 0);
        chk("R4 width out", {16'b0, img_width}, 32'd320);
        chk("R4 height out", {16'b0, img_height}, 32'd240);
        read_chk("R4 size readback", 32'h4);
        read_chk("R5 aligned size no error", 32'hC);

        // start with 3 components
        bus_write(32'h0, 32'h7, 4'hF, 0);
        chk("R3 start pulse after ack", {31'b0, start_seen}, 32'd1);
        chk("R3 start pulse one cycle", {31'b0, start_after}, 32'd0);
        chk("R3 comp count out", {29'b0, comp_count}, 32'd3);
        read_chk("R3 control readback bit0 clear", 32'h0);
        read_chk("R6 busy after start", 32'hC);

        pulse_done();
        read_chk("R7 status reads 2 after done", 32'hC);
        chk("R7 exact value 2", exp_read(32'hC), 32'd2);
        repeat (5) @(negedge clk);
        read_chk("R7 done sticky", 32'hC);

        // start and done in the same cycle: start wins
        bus_write(32'h0, 32'h5, 4'hF, 1);
        chk("R7 start pulse with done", {31'b0, start_seen}, 32'd1);
        read_chk("R7 start beats done", 32'hC);
        pulse_done();
        read_chk("R6 done after second frame", 32'hC);

        // start bit without byte lane 0 does nothing
        bus_write(32'h0, 32'hF, 4'hE, 0);
        chk("R3 no start without lane 0", {31'b0, start_seen}, 32'd0);
        read_chk("R3 count unchanged without lane 0", 32'h0);

        // byte-lane size writes and size error
        bus_write(32'h4, 32'hFFFF_FF0B, 4'b0001, 0);
        chk("R4 lane 0 only height", {img_width, img_height}, size_m);
        read_chk("R5 misaligned height sets error", 32'hC);
        bus_write(32'h4, 32'hAAAA_0010, 4'b0001, 0);
        read_chk("R5 realigned clears error", 32'hC);
        bus_write(32'h4, 32'h0143_0000, 4'b1100, 0);
        chk("R4 upper lanes width", {img_width, img_height}, size_m);
        read_chk("R5 misaligned width sets error", 32'hC);
        bus_write(32'h4, 32'h0100_0000, 4'b0100, 0);
        read_chk("R5 width fixed clears error", 32'hC);

        // held select: one ack, one commit
        @(negedge clk);
        bus_sel = 1; bus_rnw = 0; bus_addr = 32'h0; bus_wdata = 32'h3; bus_be = 4'hF;
        acks = 0; starts = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            acks += int'(bus_ack);
            starts += int'(frame_start);
        end
        bus_sel = 0; bus_be = '0;
        model_write(32'h0, 32'h3, 4'hF, 0);
        @(negedge clk);
        chk("R1 single ack for held select", acks, 32'd1);
        chk("R3 single start for held select", starts, 32'd1);
        pulse_done();

        // table: directed end entries
        bus_write(32'h100, 32'hFFFF_FF10, 4'hF, 0);
        bus_write(32'h1FC, 32'h0000_0063, 4'hF, 0);
        read_chk("R8 first entry low byte", 32'h100);
        read_chk("R8 last entry", 32'h1FC);
        bus_write(32'h104, 32'h0000_0055, 4'hE, 0);
        read_chk("R8 lane 0 disabled no write", 32'h104);

        // random table and size traffic
        for (int n = 0; n < 120; n++) begin
            logic [31:0] a, dv;
            logic [3:0] be;
            int op;
            op = $urandom_range(0, 3);
            dv = $urandom();
            be = 4'($urandom_range(0, 15));
            if (op == 0) begin
                a = 32'h4;
                if (dv[31]) dv = dv & 32'hFFF8_FFF8;
            end else begin
                a = 32'h100 + 32'($urandom_range(0, 63)) * 4;
            end
            if (op == 3) read_chk("R8 random table read", a);
            else bus_write(a, dv, be, 0);
            if (op == 0) chk("R4 random size outputs", {img_width, img_height}, size_m);
        end
        read_chk("R5 status after random sizes", 32'hC);

        // side port across all entries
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            qt_idx = 6'(i);
            #1;
            chk("R9 side port entry", {24'b0, qt_val}, {24'b0, qt_m[i]});
        end

        // unmapped and read-only
        read_chk("R10 offset 8 reads zero", 32'h8);
        read_chk("R10 misaligned table reads zero", 32'h101);
        read_chk("R10 past table reads zero", 32'h200);
        read_chk("R10 high address reads zero", 32'h8000_0004);
        bus_write(32'h8, 32'hFFFF_FFFF, 4'hF, 0);
        bus_write(32'hC, 32'hFFFF_FFFF, 4'hF, 0);
        bus_write(32'h102, 32'h0000_00EE, 4'hF, 0);
        bus_write(32'h200, 32'h0000_00EE, 4'hF, 0);
        chk("R10 status write no start", {31'b0, start_seen}, 32'd0);
        read_chk("R10 status unchanged", 32'hC);
        read_chk("R10 control unchanged", 32'h0);
        read_chk("R10 size unchanged", 32'h4);
        read_chk("R10 entry 0 unchanged", 32'h100);
        read_chk("R10 entry 1 unchanged", 32'h104);
        read_chk("R10 entry 63 unchanged", 32'h1FC);
        chk("R11 side outputs stay low", {29'b0, bus_retry, bus_err, bus_tout_sup}, 32'd0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule